// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a general-purpose I/O controller for a pin count that is a multiple of 32. Its pins are split into 32-pin banks. Each pin has a direction bit and an output latch. The latch is changed only by writing ones to a set word or a clear word. Each pin also has a level that software can read, and edge detection with separate enables for rising and falling edges. A detected edge raises a status bit that stays set until software writes a 1 to it. One interrupt output reports whether any status bit is set.

Software reaches the block through a plain 32-bit port with combinational read data. The register space is grouped by register kind, with one word per bank inside each kind, so a driver finds any pin's bit with the same arithmetic for every kind. A typical handler works bank by bank: it reads a status word, services every set bit, then writes the same value back to clear those bits.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register reads zero, and pin_o, pin_oe_o and irq_o are all zero.
- R2: Register kind k (0 level, 1 direction, 2 set, 3 clear, 4 rise enable, 5 fall enable, 6 status) for bank b is at byte address k*BANKS*4 + b*4, where BANKS = PINS/32. Pin p uses bit p%32 of bank p/32. Address bits [1:0] are ignored. Word addresses of 7*BANKS and above read zero, and writes to them change nothing.
- R3: Writing the set word forces high the output latch of every pin whose data bit is 1. Bits written as 0 leave their pins unchanged. The set word reads zero.
- R4: Writing the clear word forces low the output latch of every pin whose data bit is 1. Bits written as 0 leave their pins unchanged. The clear word reads zero.
- R5: The direction word can be read and written. pin_oe_o follows it, with 1 meaning output. pin_o always shows the output latch, and the latch keeps its value while the pin is an input.
- R6: The level word returns pin_i after a two-flop synchronizer. A change on pin_i is visible in the level word after the second rising clock edge.
- R7: When a pin's rise enable is 1, a 0-to-1 change of its synchronized level sets its status bit. The bit is visible after the third rising edge that follows the change on pin_i.
- R8: When a pin's fall enable is 1, a 1-to-0 change of its synchronized level sets its status bit. With both enables set, either edge sets the bit.
- R9: An edge whose direction is not enabled for that pin leaves its status bit at 0.
- R10: A status bit stays set until a 1 is written to its position in the status word. Writing 0 to a status bit has no effect.
- R11: If a new enabled edge and a write-1 clear reach the same status bit on the same clock edge, the bit stays set.
- R12: irq_o is the OR of every status bit in every bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W | Byte address, shared by reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | PINS | Pin input levels, asynchronous |
| pin_o | output | PINS | Output latch values |
| pin_oe_o | output | PINS | Output enables (direction) |
| irq_o | output | 1 | OR of all edge status bits |

## Verification
The two functions that can meet on one clock edge are the setting of a status bit by a new edge and the clearing of that same bit by a software write. The bench forces this on purpose. It first clears a bit that is already set and lets the pin settle. It then raises the pin and times the write-1 clear so that it is sampled on the same edge that the synchronized rise reaches the status register. One cycle later the bit must still read 1, and a second clear must then remove it. The random phase drives pin changes and status clears independently on every cycle. It therefore hits the same collision many times, and a cycle-accurate bench model judges each case under the rule that the edge wins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_W    = 32;
  localparam int REG_KINDS = 7;

  // order fixes the address map
  typedef enum logic [2:0] {
    RK_LEVEL = 3'd0,
    RK_DIR   = 3'd1,
    RK_SET   = 3'd2,
    RK_CLR   = 3'd3,
    RK_RISE  = 3'd4,
    RK_FALL  = 3'd5,
    RK_STS   = 3'd6
  } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dir_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic              wr_rise_i,
  input  logic              wr_fall_i,
  input  logic              wr_sts_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] lvl_i,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] out_o,
  output logic [BANK_W-1:0] rise_en_o,
  output logic [BANK_W-1:0] fall_en_o,
  output logic [BANK_W-1:0] sts_o
);
  logic [BANK_W-1:0] dir_q, out_q, rise_q, fall_q, sts_q, prev_q;
  logic [BANK_W-1:0] edge_hit, sts_clr, sts_d, out_d;

  assign edge_hit = (rise_q & lvl_i & ~prev_q) | (fall_q & ~lvl_i & prev_q);
  assign sts_clr  = wr_sts_i ? wdata_i : '0;
  // new edge beats a same-cycle clear
  assign sts_d    = (sts_q & ~sts_clr) | edge_hit;

  always_comb begin
    out_d = out_q;
    if (wr_set_i) out_d = out_d | wdata_i;
    if (wr_clr_i) out_d = out_d & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      sts_q  <= '0;
      prev_q <= '0;
    end else begin
      if (wr_dir_i)  dir_q  <= wdata_i;
      if (wr_rise_i) rise_q <= wdata_i;
      if (wr_fall_i) fall_q <= wdata_i;
      out_q  <= out_d;
      sts_q  <= sts_d;
      prev_q <= lvl_i;
    end
  end

  assign dir_o     = dir_q;
  assign out_o     = out_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign sts_o     = sts_q;

  // R10
  sts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sts_i |=> (($past(sts_q) & ~sts_q) == '0));
  // R11
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit != '0) |=> ((sts_q & $past(edge_hit)) == $past(edge_hit)));
  // R3
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set_i || wr_clr_i) |=> $stable(out_q));
  // R5
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(dir_q));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 64,
  parameter int ADDR_W = $clog2(REG_KINDS * (PINS / BANK_W) * 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic              irq_o
);
  localparam int BANKS  = PINS / BANK_W;
  localparam int NWORDS = REG_KINDS * BANKS;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic [NWORDS-1:0] hit;
  logic [31:0]       rd_word [NWORDS];
  logic [PINS-1:0]   lvl, sts_all;
  logic [1:0]        unused_addr_lo;

  assign word_idx       = addr_i[ADDR_W-1:2];
  assign unused_addr_lo = addr_i[1:0];

  gpio_sync #(.WIDTH(PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_i),
    .sync_o (lvl)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_dec
    assign hit[w] = (word_idx == WORD_W'(w));
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] dir_b, out_b, rise_b, fall_b, sts_b, lvl_b;

    assign lvl_b = lvl[b*BANK_W +: BANK_W];

    gpio_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_dir_i (wr_en_i & hit[int'(RK_DIR)  * BANKS + b]),
      .wr_set_i (wr_en_i & hit[int'(RK_SET)  * BANKS + b]),
      .wr_clr_i (wr_en_i & hit[int'(RK_CLR)  * BANKS + b]),
      .wr_rise_i(wr_en_i & hit[int'(RK_RISE) * BANKS + b]),
      .wr_fall_i(wr_en_i & hit[int'(RK_FALL) * BANKS + b]),
      .wr_sts_i (wr_en_i & hit[int'(RK_STS)  * BANKS + b]),
      .wdata_i  (wdata_i),
      .lvl_i    (lvl_b),
      .dir_o    (dir_b),
      .out_o    (out_b),
      .rise_en_o(rise_b),
      .fall_en_o(fall_b),
      .sts_o    (sts_b)
    );

    assign pin_o[b*BANK_W +: BANK_W]    = out_b;
    assign pin_oe_o[b*BANK_W +: BANK_W] = dir_b;
    assign sts_all[b*BANK_W +: BANK_W]  = sts_b;

    // set/clear words read as zero
    assign rd_word[int'(RK_LEVEL) * BANKS + b] = lvl_b;
    assign rd_word[int'(RK_DIR)   * BANKS + b] = dir_b;
    assign rd_word[int'(RK_SET)   * BANKS + b] = '0;
    assign rd_word[int'(RK_CLR)   * BANKS + b] = '0;
    assign rd_word[int'(RK_RISE)  * BANKS + b] = rise_b;
    assign rd_word[int'(RK_FALL)  * BANKS + b] = fall_b;
    assign rd_word[int'(RK_STS)   * BANKS + b] = sts_b;
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (hit[w]) rdata_o = rd_word[w];
    end
  end

  assign irq_o = |sts_all;

  // R2
  dec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  // R12
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !$past(irq_o)) |-> (rdata_o != 32'hFFFF_FFFF || !hit[int'(RK_STS) * BANKS]));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PINS   = 64;
  localparam int BANKS  = PINS / 32;
  localparam int ADDR_W = $clog2(7 * BANKS * 4);

  logic              clk = 0;
  logic              rst_n = 0;
  logic              wr_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [PINS-1:0]   pin_in = '0;
  logic [PINS-1:0]   pin_out, pin_oe;
  logic              irq;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_bank_ctrl #(.PINS(PINS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // bench model of the requirements
  logic [PINS-1:0] m_s1, m_s2, m_prev, m_dir, m_out, m_rise, m_fall, m_sts;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_dir <= '0;
      m_out <= '0; m_rise <= '0; m_fall <= '0; m_sts <= '0;
    end else begin
      logic [PINS-1:0] ed, clr, nout;
      int wd, k, b;
      ed   = (m_rise & m_s2 & ~m_prev) | (m_fall & ~m_s2 & m_prev);
      clr  = '0;
      nout = m_out;
      wd   = int'(addr) >> 2;
      if (wr_en && wd < 7 * BANKS) begin
        k = wd / BANKS;
        b = wd % BANKS;
        case (k)
          1: m_dir[b*32 +: 32]  <= wdata;
          2: nout[b*32 +: 32]   = nout[b*32 +: 32] | wdata;
          3: nout[b*32 +: 32]   = nout[b*32 +: 32] & ~wdata;
          4: m_rise[b*32 +: 32] <= wdata;
          5: m_fall[b*32 +: 32] <= wdata;
          6: clr[b*32 +: 32]    = wdata;
          default: ;
        endcase
      end
      m_out  <= nout;
      m_sts  <= (m_sts & ~clr) | ed;
      m_s1   <= pin_in;
      m_s2   <= m_s1;
      m_prev <= m_s2;
    end
  end

  function automatic logic [31:0] model_read(input int a);
    int wd, k, b;
    wd = a >> 2;
    if (wd >= 7 * BANKS) return '0;
    k = wd / BANKS;
    b = wd % BANKS;
    case (k)
      0: return m_s2[b*32 +: 32];
      1: return m_dir[b*32 +: 32];
      4: return m_rise[b*32 +: 32];
      5: return m_fall[b*32 +: 32];
      6: return m_sts[b*32 +: 32];
      default: return '0;
    endcase
  endfunction

  function automatic int ra(input int kind, input int bank);
    return kind * BANKS * 4 + bank * 4;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = ADDR_W'(a);
    #1;
    d = rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [PINS-1:0] keep_o, keep_oe;
    void'($urandom(32'd1357));

    // R1
    #(CLK_PERIOD * 2 + 1);
    check("R1 pin_o", 64'(pin_out), 64'h0);
    check("R1 pin_oe_o", 64'(pin_oe), 64'h0);
    check("R1 irq_o", 64'(irq), 64'h0);
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 7; k++) begin
      for (int b = 0; b < BANKS; b++) begin
        rd(ra(k, b), d);
        check("R1 reg zero", 64'(d), 64'h0);
      end
    end

    // R3 / R4
    wr(ra(2, 0), 32'h0000_00F0);
    check("R3 set", 64'(pin_out), 64'h0000_0000_0000_00F0);
    wr(ra(2, 0), 32'h0);
    check("R3 zero no effect", 64'(pin_out), 64'h0000_0000_0000_00F0);
    rd(ra(2, 0), d);
    check("R3 set reads zero", 64'(d), 64'h0);
    wr(ra(3, 0), 32'h0000_0030);
    check("R4 clear", 64'(pin_out), 64'h0000_0000_0000_00C0);
    rd(ra(3, 0), d);
    check("R4 clear reads zero", 64'(d), 64'h0);

    // R5: latch held while input, then direction on bank 1
    check("R5 oe still zero", 64'(pin_oe), 64'h0);
    wr(ra(1, 1), 32'h0000_0100);
    check("R5 oe pin40", 64'(pin_oe), 64'h0000_0100_0000_0000);
    check("R5 latch kept", 64'(pin_out), 64'h0000_0000_0000_00C0);
    rd(ra(1, 1), d);
    check("R5 dir readback", 64'(d), 64'h100);

    // R6: two-flop latency, pin 40 = bank1 bit8
    @(negedge clk); pin_in[40] = 1'b1;
    @(negedge clk); rd(ra(0, 1), d);
    check("R6 level after 1 edge", 64'(d[8]), 64'h0);
    @(negedge clk); rd(ra(0, 1), d);
    check("R6 level after 2 edges", 64'(d[8]), 64'h1);

    // R7 / R8 / R9
    wr(ra(4, 0), 32'h0000_0001);
    wr(ra(5, 0), 32'h0000_0002);
    @(negedge clk); pin_in[0] = 1'b1; pin_in[1] = 1'b1; pin_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); rd(ra(6, 0), d);
    check("R7 status not before 3rd edge", 64'(d), 64'h0);
    @(negedge clk); rd(ra(6, 0), d);
    check("R7 rise sets status", 64'(d), 64'h1);
    check("R12 irq set", 64'(irq), 64'h1);
    @(negedge clk); pin_in[1] = 1'b0; pin_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd(ra(6, 0), d);
    check("R8 fall sets status", 64'(d), 64'h3);
    check("R9 disabled pin2 clear", 64'(d[2]), 64'h0);

    // R10
    wr(ra(6, 0), 32'h0);
    rd(ra(6, 0), d);
    check("R10 write zero keeps", 64'(d), 64'h3);
    wr(ra(6, 0), 32'h1);
    rd(ra(6, 0), d);
    check("R10 write one clears", 64'(d), 64'h2);
    check("R12 irq still set", 64'(irq), 64'h1);
    wr(ra(6, 0), 32'h2);
    check("R12 irq cleared", 64'(irq), 64'h0);

    // R11: clear sampled on the same edge as a new rise
    @(negedge clk); pin_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = ADDR_W'(ra(6, 0)); wdata = 32'h1; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(ra(6, 0), d);
    check("R11 edge beats clear", 64'(d), 64'h1);
    wr(ra(6, 0), 32'h1);
    rd(ra(6, 0), d);
    check("R11 later clear works", 64'(d), 64'h0);

    // R2: unmapped words, ignored low address bits
    keep_o = pin_out; keep_oe = pin_oe;
    wr(7 * BANKS * 4, 32'hFFFF_FFFF);
    wr(7 * BANKS * 4 + 4, 32'hFFFF_FFFF);
    check("R2 unmapped write out", 64'(pin_out), 64'(keep_o));
    check("R2 unmapped write oe", 64'(pin_oe), 64'(keep_oe));
    rd(7 * BANKS * 4, d);
    check("R2 unmapped reads zero", 64'(d), 64'h0);
    wr(ra(2, 0) + 3, 32'h1);
    check("R2 low bits ignored", 64'(pin_out[0]), 64'h1);
    wr(ra(1, 0) + 2, 32'h8000_0000);
    check("R2 pin31 bit position", 64'(pin_oe[31]), 64'h1);

    // random phase against the model
    for (int i = 0; i < 2000; i++) begin
      int a;
      @(negedge clk);
      wr_en = 0;
      check("R5 pin_o", 64'(pin_out), 64'(m_out));
      check("R5 pin_oe_o", 64'(pin_oe), 64'(m_dir));
      check("R12 irq", 64'(irq), 64'(|m_sts));
      a = int'($urandom_range(0, (1 << ADDR_W) - 1));
      rd(a, d);
      check("R2 random read", 64'(d), 64'(model_read(a)));
      pin_in = pin_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      if ($urandom_range(0, 2) != 0) begin
        int k;
        k = ($urandom_range(0, 3) == 0) ? 6 : int'($urandom_range(1, 7));
        a = (k == 7) ? 7 * BANKS * 4 : ra(k, int'($urandom_range(0, BANKS - 1)));
        addr = ADDR_W'(a);
        wdata = (k == 6) ? model_read(a) | $urandom : $urandom;
        wr_en = 1;
      end
    end
    @(negedge clk); wr_en = 0;
    summary();
  end
endmodule